// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block sits in the feedback path of an integer-N frequency synthesizer, after a dual-modulus prescaler. The prescaler divides the oscillator by either N or N+1 and reports the end of each of its periods as a one-clock strobe. The divider counts those strobes with two counters. A program counter sets how many prescaler periods make up one output period. A swallow counter sets how many of those periods use the longer modulus. The overall ratio from the oscillator clock to the output pulse is therefore P·N + S.

The swallow count S comes directly from a small channel-select word. With the default prescaler moduli of 22/23 and a program count of 10, the eight select codes give the adjacent ratios 220 through 227. A new select value takes effect only when a divide cycle ends, so every output period uses a single ratio. Each output pulse is one clock wide and can drive the feedback input of a phase-frequency detector. An option selects a registered output pulse, which lags the terminal count by one clock, or a combinational output pulse.

Top module: `pswallow_div`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `div_out` is 0 and `mod_hi` is 0, because the swallow count resets to 0.
- R2: With a steady select value S, consecutive `div_out` pulses are exactly N_BASE·P_CNT + S clocks apart, which is 220 + S for the defaults. This holds for every S from 0 to 7.
- R3: Within one output period, `mod_hi` is high for exactly the first S prescaler periods and low for the rest. `mod_hi` changes only on the clock edge that follows a `pre_tick`.
- R4: `div_out` is high for exactly one clock per divide cycle and is never high on two consecutive clocks.
- R5: A change of `chan_sel` during a divide cycle does not alter that cycle's ratio. The new value governs the next cycle, which starts on the edge that ends the current one.
- R6: Every output period contains exactly P_CNT prescaler strobes. With the registered output, `div_out` rises on the clock after the P_CNT-th strobe.
- R7: With select value 0, `mod_hi` stays low for the whole divide cycle, and the ratio is N_BASE·P_CNT.
- R8: While `pre_tick` is held low, `mod_hi` holds its value and no `div_out` pulse appears. A stalled cycle stretches by exactly the number of stalled clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock shared with the prescaler |
| rst | input | 1 | Synchronous reset, active high |
| chan_sel | input | SEL_W | Swallow count S; sampled when a divide cycle ends |
| pre_tick | input | 1 | One-clock strobe marking the end of each prescaler period |
| mod_hi | output | 1 | Modulus control: 1 asks the prescaler for N+1, 0 for N |
| div_out | output | 1 | One-clock pulse per complete divide cycle |

## Verification
The bench drives the divider from a behavioural N/N+1 prescaler. It sweeps every select value from 0 to 7 and checks each interval between pulses against 220 + S. It also checks that the number of long prescaler periods equals S, which would expose a swallow counter that stops one period early or late. Further runs change the select value once, and then twice, in the middle of a cycle. These show whether the value is captured only at the boundary. Two stalls of the prescaler, one while the modulus control is high and one while it is low, test that the counters advance only on strobes. Each stall must lengthen the period by exactly the number of stalled clocks.

// File: rtl/psd_pkg.sv
package psd_pkg;

   // Overall division ratio from oscillator clock to output pulse.
   function automatic int div_ratio(input int n_base, input int p_cnt, input int s_cnt);
      return n_base * p_cnt + s_cnt;
   endfunction

   // Width needed to hold values 0..max_val.
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/psd_chan_latch.sv
module psd_chan_latch #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wrap,
   input  logic [SEL_W-1:0] sel_in,
   output logic [SEL_W-1:0] s_val
);

   // Swallow count captured only at the cycle boundary.
   always_ff @(posedge clk) begin
      if (rst)
         s_val <= '0;
      else if (wrap)
         s_val <= sel_in;
   end

endmodule

// File: rtl/psd_prog_cnt.sv
module psd_prog_cnt #(
   parameter int P_CNT = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   output logic wrap
);

   localparam int CW = psd_pkg::cnt_width(P_CNT - 1);
   localparam logic [CW-1:0] LAST = CW'(P_CNT - 1);

   logic [CW-1:0] pc_q;

   assign wrap = tick && (pc_q == LAST);

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else if (wrap)
         pc_q <= '0;
      else if (tick)
         pc_q <= pc_q + 1'b1;
   end

endmodule

// File: rtl/psd_swallow_cnt.sv
module psd_swallow_cnt #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             wrap,
   input  logic [SEL_W-1:0] s_val,
   output logic             mod_hi
);

   logic [SEL_W-1:0] sc_q;

   // Long modulus until the swallow count has been consumed.
   assign mod_hi = (sc_q != s_val);

   always_ff @(posedge clk) begin
      if (rst)
         sc_q <= '0;
      else if (wrap)
         sc_q <= '0;
      else if (tick && mod_hi)
         sc_q <= sc_q + 1'b1;
   end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
   parameter int N_BASE  = 22,
   parameter int P_CNT   = 10,
   parameter int SEL_W   = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] chan_sel,
   input  logic             pre_tick,
   output logic             mod_hi,
   output logic             div_out
);

   localparam int S_MAX     = (1 << SEL_W) - 1;
   localparam int RATIO_MIN = psd_pkg::div_ratio(N_BASE, P_CNT, 0);

   // Elaboration-time parameter checks.
   if (SEL_W < 1) begin : g_bad_sel_w
      $error("pswallow_div: SEL_W must be at least 1");
   end
   if (P_CNT <= S_MAX) begin : g_bad_p_cnt
      $error("pswallow_div: P_CNT must exceed the largest swallow count");
   end
   if (N_BASE < 2) begin : g_bad_n_base
      $error("pswallow_div: N_BASE must be at least 2");
   end
   if (RATIO_MIN < 4) begin : g_bad_ratio
      $error("pswallow_div: division ratio too small");
   end

   logic             wrap;
   logic [SEL_W-1:0] s_val;

   psd_prog_cnt #(.P_CNT(P_CNT)) u_prog (
      .clk  (clk),
      .rst  (rst),
      .tick (pre_tick),
      .wrap (wrap)
   );

   psd_chan_latch #(.SEL_W(SEL_W)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .wrap   (wrap),
      .sel_in (chan_sel),
      .s_val  (s_val)
   );

   psd_swallow_cnt #(.SEL_W(SEL_W)) u_swallow (
      .clk    (clk),
      .rst    (rst),
      .tick   (pre_tick),
      .wrap   (wrap),
      .s_val  (s_val),
      .mod_hi (mod_hi)
   );

   if (REG_OUT) begin : g_out_reg
      logic div_q;
      always_ff @(posedge clk) begin
         if (rst)
            div_q <= 1'b0;
         else
            div_q <= wrap;
      end
      assign div_out = div_q;
   end else begin : g_out_comb
      assign div_out = wrap;
   end

endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
   parameter int P_CNT   = 10,
   parameter bit REG_OUT = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic pre_tick,
   input logic mod_hi,
   input logic div_out
);

   localparam int TW = psd_pkg::cnt_width(P_CNT + 1);

   // Strobes seen since the last output pulse.
   logic [TW-1:0] tick_cnt;

   always_ff @(posedge clk) begin
      if (rst)
         tick_cnt <= '0;
      else if (div_out)
         tick_cnt <= '0;
      else if (pre_tick && (tick_cnt <= TW'(P_CNT)))
         tick_cnt <= tick_cnt + 1'b1;
   end

   // R3: modulus control moves only after a prescaler strobe
   p_mod_moves_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
      !$stable(mod_hi) |-> $past(pre_tick));

   // R3: the last prescaler period of a cycle always uses the short modulus
   p_last_period_short_r3: assert property (@(posedge clk) disable iff (rst)
      (pre_tick && (tick_cnt == TW'(P_CNT - 1))) |-> !mod_hi);

   // R4: output pulse is a single clock wide
   p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
      div_out |=> !div_out);

   // R6: the strobe count within a cycle never exceeds the program count
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
      tick_cnt <= TW'(P_CNT));

   if (REG_OUT) begin : g_chk_reg
      // R6: registered pulse follows the P_CNT-th strobe
      p_pulse_after_count_r6: assert property (@(posedge clk) disable iff (rst)
         div_out |-> (tick_cnt == TW'(P_CNT)));
      // R8: no strobe, no pulse on the next clock
      p_idle_no_pulse_r8: assert property (@(posedge clk) disable iff (rst)
         !pre_tick |=> !div_out);
   end else begin : g_chk_comb
      // R6: combinational pulse coincides with the P_CNT-th strobe
      p_pulse_at_count_r6: assert property (@(posedge clk) disable iff (rst)
         div_out |-> (pre_tick && (tick_cnt == TW'(P_CNT - 1))));
      // R8: no strobe, no pulse
      p_idle_no_pulse_r8: assert property (@(posedge clk) disable iff (rst)
         !pre_tick |-> !div_out);
   end

endmodule

bind pswallow_div pswallow_div_chk #(
   .P_CNT   (P_CNT),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pre_tick (pre_tick),
   .mod_hi   (mod_hi),
   .div_out  (div_out)
);

// File: tb/tb_pswallow_div.sv
`timescale 1ns/1ps
module tb_pswallow_div;

   localparam int N_BASE = 22;
   localparam int P_CNT  = 10;
   localparam int SEL_W  = 3;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [SEL_W-1:0] sel = '0;
   logic             run = 1'b1;
   logic             pre_tick;
   logic             mod_hi;
   logic             div_out;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;   // 50 MHz

   pswallow_div #(
      .N_BASE  (N_BASE),
      .P_CNT   (P_CNT),
      .SEL_W   (SEL_W),
      .REG_OUT (1'b1)
   ) dut (
      .clk      (clk),
      .rst      (rst),
      .chan_sel (sel),
      .pre_tick (pre_tick),
      .mod_hi   (mod_hi),
      .div_out  (div_out)
   );

   // Behavioural dual-modulus prescaler: period is N+1 clocks while mod_hi is high, else N.
   int pre_cnt;
   assign pre_tick = run && (pre_cnt == (mod_hi ? N_BASE : N_BASE - 1));
   always @(posedge clk) begin
      if (rst)
         pre_cnt <= 0;
      else if (run)
         pre_cnt <= pre_tick ? 0 : pre_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Monitor (samples at falling edge)
   int  cyc = 0, last_cyc = 0, pulses = 0;
   int  s_cur = 0, hi_cnt = 0, tk_cnt = 0, paused = 0;
   bit  have_last = 0, zero_hi = 0, sel_moved = 0, first_after_rst = 1;
   logic mod_hold = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst) begin
         chk(div_out === 1'b0, "R1 div_out in reset", int'(div_out), 0);
         chk(mod_hi === 1'b0, "R1 mod_hi in reset", int'(mod_hi), 0);
      end else begin
         if (first_after_rst) begin
            first_after_rst = 0;
            chk(div_out === 1'b0 && mod_hi === 1'b0, "R1 after reset",
                int'({div_out, mod_hi}), 0);
         end
         if (!run) begin
            paused++;
            chk(div_out === 1'b0, "R8 no pulse while stalled", int'(div_out), 0);
            chk(mod_hi === mod_hold, "R8 mod_hi held while stalled", int'(mod_hi), int'(mod_hold));
         end
         if (pre_tick) begin
            tk_cnt++;
            if (mod_hi) hi_cnt++;
         end
         if (!div_out && s_cur == 0 && mod_hi) zero_hi = 1;
         if (div_out) begin
            chk(hi_cnt == s_cur, "R3 long periods per cycle", hi_cnt, s_cur);
            chk(tk_cnt == P_CNT, "R6 strobes per cycle", tk_cnt, P_CNT);
            if (s_cur == 0)
               chk(!zero_hi, "R7 mod_hi low with select 0", int'(zero_hi), 0);
            if (have_last) begin
               if (sel_moved)
                  chk(cyc - last_cyc == N_BASE * P_CNT + s_cur + paused,
                      "R5 ratio unchanged by mid-cycle select",
                      cyc - last_cyc, N_BASE * P_CNT + s_cur + paused);
               else
                  chk(cyc - last_cyc == N_BASE * P_CNT + s_cur + paused,
                      "R2 pulse interval", cyc - last_cyc, N_BASE * P_CNT + s_cur + paused);
            end
            have_last = 1;
            last_cyc  = cyc;
            s_cur     = int'(sel);
            hi_cnt    = 0;
            tk_cnt    = 0;
            paused    = 0;
            zero_hi   = 0;
            sel_moved = 0;
            pulses++;
         end
         if (div_out && pre_tick)
            chk(0, "R4 pulse overlaps strobe", 1, 0);
      end
   end

   // R4: pulse width
   logic div_prev = 1'b0;
   always @(negedge clk) begin
      if (!rst && div_out && div_prev)
         chk(0, "R4 pulse wider than one clock", 2, 1);
      div_prev <= div_out;
   end

   task automatic wait_pulses(input int n);
      int target;
      target = pulses + n;
      while (pulses < target) @(negedge clk);
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      #2 rst = 1'b0;

      // R2/R3/R6/R7: sweep every select value
      for (int s = 0; s < 8; s++) begin
         wait_pulses(1);
         #2 sel = SEL_W'(s);
         wait_pulses(3);
      end

      // R5: single mid-cycle change (7 -> 2)
      wait_pulses(1);
      repeat (100) @(negedge clk);
      #2 sel = 3'd2; sel_moved = 1;
      wait_pulses(2);

      // R5: two changes within one cycle
      repeat (30) @(negedge clk);
      #2 sel = 3'd6; sel_moved = 1;
      repeat (50) @(negedge clk);
      #2 sel = 3'd1;
      wait_pulses(2);

      // R8: stall while mod_hi is high (first period of a cycle with S=1)
      repeat (5) @(negedge clk);
      #2 mod_hold = mod_hi; run = 1'b0;
      chk(mod_hi === 1'b1, "R3 mod_hi high in first period", int'(mod_hi), 1);
      repeat (40) @(negedge clk);
      #2 run = 1'b1;
      wait_pulses(1);

      // R8: stall while mod_hi is low
      repeat (120) @(negedge clk);
      #2 mod_hold = mod_hi; run = 1'b0;
      repeat (25) @(negedge clk);
      #2 run = 1'b1;
      wait_pulses(2);

      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

endmodule